// File: doc/BRIEF.md
# DRAM Refresh Cycle Inserter

This block works next to the bus sequencer of an 8-bit processor. It takes bus cycles from the processor so that dynamic memory gets refreshed, whatever instruction is running. A free-running interval timer decides when a row needs refreshing. When it does, the block raises a hold request. The processor sequencer reports the end of each machine cycle on a boundary input. At the first such boundary the block takes the bus for a fixed number of clocks. During those clocks it drives its 8-bit row counter onto the low address lines and pulls an active-low refresh strobe. When the cycle ends, the row counter moves on and the processor is released.

Software-visible configuration comes in on two inputs: an enable bit and an interval value. Clearing the enable bit stops all refresh activity, so no cycles are taken from the processor.

Top module: `refresh_inserter`

## Requirements
- R1: While reset is high and on the first clock after it, hold_req is 0, rfsh_n is 1 and rfsh_addr is 0.
- R2: While cfg_en is 1, the interval timer expires once every cfg_interval+1 clocks. Each expiry makes a refresh pending, and hold_req shows this from the next clock.
- R3: A pending refresh starts only on a clock edge where mc_boundary is 1. While mc_boundary stays 0, hold_req stays 1 and rfsh_n stays 1.
- R4: Once a refresh starts, rfsh_n is 0 for exactly CYC_LEN consecutive clocks, beginning the clock after the accepting edge.
- R5: rfsh_addr carries the current row and holds it unchanged for as long as rfsh_n is 0.
- R6: The row advances by one at the edge that ends each refresh, and wraps from 255 to 0.
- R7: Expiries that occur while a refresh is already pending merge into one request, which produces a single refresh.
- R8: When cfg_en is 0, the timer is held at zero and any pending request is dropped. A refresh that is already running completes, and no new one begins.
- R9: hold_req is 1 from the clock after a request becomes pending through the last strobe clock, and 0 at all other times.
- R10: If the timer expires on the same edge that starts a refresh, the new request stays pending, and hold_req does not drop after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Refresh enable |
| cfg_interval | input | INTV_W | Interval value: expiry every value+1 clocks |
| mc_boundary | input | 1 | Processor is at a machine-cycle boundary |
| hold_req | output | 1 | Asks the processor sequencer to pause |
| rfsh_addr | output | ROW_W | Refresh row for address lines 0 upward |
| rfsh_n | output | 1 | Active-low refresh strobe |

## Verification
Two events can land on the same edge: a timer expiry and the acceptance of a pending request at a boundary. A second collision is an expiry and an earlier request that has not yet been served. The bench provokes both on purpose. With an interval of zero the timer expires on every clock, and holding mc_boundary low lets several expiries build up behind one request. Random intervals and boundary patterns add further collisions. Every clock, a cycle model compares hold_req, rfsh_n and rfsh_addr. In addition, a count of strobes proves that merged expiries produce exactly one refresh, and a check of hold_req after each strobe proves that a coincident expiry is kept.

// File: rtl/rfr_pkg.sv
package rfr_pkg;
  // events passed between the timer, sequencer and row counter
  typedef struct packed {
    logic expire;
    logic done;
  } rfr_evt_t;

  function automatic int unsigned rfr_cnt_w(input int unsigned len);
    return (len < 2) ? 1 : $clog2(len + 1);
  endfunction
endpackage

// File: rtl/rfr_interval_timer.sv
module rfr_interval_timer #(
  parameter int INTV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [INTV_W-1:0] interval,
  output logic              expire
);
  logic [INTV_W-1:0] tmr_q;

  assign expire = en && (tmr_q == interval);

  always_ff @(posedge clk) begin
    if (rst || !en)  tmr_q <= '0;
    else if (expire) tmr_q <= '0;
    else             tmr_q <= tmr_q + 1'b1;
  end
endmodule

// File: rtl/rfr_cycle_seq.sv
module rfr_cycle_seq #(
  parameter int CYC_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic expire,
  input  logic boundary,
  output logic hold_q,
  output logic strobe_n_q,
  output logic done
);
  localparam int CNT_W = rfr_pkg::rfr_cnt_w(CYC_LEN);

  logic             pend_q, pend_nxt, start;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  always_comb begin
    start    = en && pend_q && boundary && (cnt_q == '0);
    pend_nxt = en && ((pend_q && !start) || expire);
    if (start)             cnt_nxt = CNT_W'(CYC_LEN);
    else if (cnt_q != '0)  cnt_nxt = cnt_q - 1'b1;
    else                   cnt_nxt = '0;
  end

  assign done = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= 1'b0;
      cnt_q      <= '0;
      hold_q     <= 1'b0;
      strobe_n_q <= 1'b1;
    end else begin
      pend_q     <= pend_nxt;
      cnt_q      <= cnt_nxt;
      hold_q     <= pend_nxt || (cnt_nxt != '0);
      strobe_n_q <= (cnt_nxt == '0);
    end
  end
endmodule

// File: rtl/rfr_row_ctr.sv
module rfr_row_ctr #(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [ROW_W-1:0] row_q
);
  always_ff @(posedge clk) begin
    if (rst)      row_q <= '0;
    else if (inc) row_q <= row_q + 1'b1;
  end
endmodule

// File: rtl/refresh_inserter.sv
module refresh_inserter #(
  parameter int INTV_W  = 8,
  parameter int ROW_W   = 8,
  parameter int CYC_LEN = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic [INTV_W-1:0] cfg_interval,
  input  logic              mc_boundary,
  output logic              hold_req,
  output logic [ROW_W-1:0]  rfsh_addr,
  output logic              rfsh_n
);
  rfr_pkg::rfr_evt_t evt;

  rfr_interval_timer #(.INTV_W(INTV_W)) u_tmr (
    .clk(clk), .rst(rst), .en(cfg_en), .interval(cfg_interval),
    .expire(evt.expire)
  );

  rfr_cycle_seq #(.CYC_LEN(CYC_LEN)) u_seq (
    .clk(clk), .rst(rst), .en(cfg_en), .expire(evt.expire),
    .boundary(mc_boundary), .hold_q(hold_req), .strobe_n_q(rfsh_n),
    .done(evt.done)
  );

  rfr_row_ctr #(.ROW_W(ROW_W)) u_row (
    .clk(clk), .rst(rst), .inc(evt.done), .row_q(rfsh_addr)
  );
endmodule

// File: rtl/refresh_inserter_chk.sv
module refresh_inserter_chk #(
  parameter int ROW_W   = 8,
  parameter int CYC_LEN = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_en,
  input logic             mc_boundary,
  input logic             hold_req,
  input logic [ROW_W-1:0] rfsh_addr,
  input logic             rfsh_n
);
  localparam int LW = rfr_pkg::rfr_cnt_w(CYC_LEN) + 1;
  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || rfsh_n) low_cnt <= '0;
    else               low_cnt <= low_cnt + 1'b1;
  end

  // R9
  strobe_in_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rfsh_n |-> hold_req);

  // R3
  start_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rfsh_n) |-> $past(mc_boundary));

  // R5
  addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!rfsh_n && $past(!rfsh_n)) |-> $stable(rfsh_addr));

  // R6
  row_advance_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rfsh_n) |-> (rfsh_addr == ROW_W'($past(rfsh_addr) + 1'b1)));

  // R4
  strobe_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rfsh_n) |-> (low_cnt == LW'(CYC_LEN)));

  // R8
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!cfg_en) && $past(rfsh_n)) |-> !hold_req);
endmodule

bind refresh_inserter refresh_inserter_chk #(.ROW_W(ROW_W), .CYC_LEN(CYC_LEN)) u_chk (
  .clk(clk), .rst(rst), .cfg_en(cfg_en), .mc_boundary(mc_boundary),
  .hold_req(hold_req), .rfsh_addr(rfsh_addr), .rfsh_n(rfsh_n)
);

// File: tb/refresh_inserter_bench.sv
module refresh_inserter_bench;
  localparam int CYC = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [7:0] intv = '0;
  logic       bnd = 1'b0;
  logic       hold_req, rfsh_n;
  logic [7:0] rfsh_addr;

  int checks = 0, fails = 0;
  bit done_flag = 0;

  // reference state
  logic [7:0] m_tmr = '0, m_row = '0;
  logic       m_pend = 0;
  int         m_cnt = 0;

  always #10 clk = ~clk;

  refresh_inserter u_refresh_inserter (
    .clk(clk), .rst(rst), .cfg_en(en), .cfg_interval(intv),
    .mc_boundary(bnd), .hold_req(hold_req), .rfsh_addr(rfsh_addr),
    .rfsh_n(rfsh_n)
  );

  function automatic logic exp_hold();  return m_pend || (m_cnt != 0); endfunction
  function automatic logic exp_strb();  return (m_cnt == 0);           endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  // one clock of the reference model (R2, R3, R7, R8, R10)
  task automatic model_step();
    logic ex, st;
    ex = 0;
    st = en && m_pend && bnd && (m_cnt == 0);
    if (!en) m_tmr = '0;
    else begin
      ex = (m_tmr == intv);
      m_tmr = ex ? 8'd0 : m_tmr + 8'd1;
    end
    m_pend = en && ((m_pend && !st) || ex);
    if (st) m_cnt = CYC;
    else if (m_cnt != 0) begin
      if (m_cnt == 1) m_row = m_row + 8'd1;  // R6
      m_cnt = m_cnt - 1;
    end
  endtask

  task automatic compare();
    check(hold_req === exp_hold(), "R9 hold_req", hold_req, exp_hold());
    check(rfsh_n === exp_strb(), "R4 rfsh_n", rfsh_n, exp_strb());
    check(rfsh_addr === m_row, "R5 rfsh_addr", rfsh_addr, m_row);
  endtask

  task automatic cyc(input logic e, input logic [7:0] iv, input logic b);
    en = e; intv = iv; bnd = b;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    int falls;
    bit wrapped, held;
    logic prev_n;
    logic [7:0] prev_a;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 during reset
    check(hold_req === 0 && rfsh_n === 1 && rfsh_addr === 0, "R1 reset", hold_req, 0);
    @(posedge clk);
    @(negedge clk);
    rst = 0;
    check(hold_req === 0 && rfsh_n === 1 && rfsh_addr === 0, "R1 after reset", rfsh_addr, 0);

    // R2, R3, R7: several expiries with no boundary
    for (int i = 0; i < 20; i++) cyc(1, 8'd5, 0);
    check(hold_req === 1 && rfsh_n === 1, "R3 waits for boundary", rfsh_n, 1);
    falls = 0; prev_n = rfsh_n;
    cyc(1, 8'd5, 1);
    for (int i = 0; i < 10; i++) begin
      if (prev_n && !rfsh_n) falls++;
      prev_n = rfsh_n;
      cyc(1, 8'd5, 0);
    end
    check(falls == 1, "R7 merged single refresh", falls, 1);

    // R8 disable
    held = 0;
    for (int i = 0; i < 50; i++) begin
      cyc(0, 8'd2, 1'($urandom_range(0, 1)));
      if (i > 4 && (hold_req || !rfsh_n)) held = 1;
    end
    check(!held, "R8 disabled stays quiet", held, 0);

    // R6 wrap and R10 coincident expiry (interval 0 expires every clock)
    wrapped = 0; held = 1; prev_n = rfsh_n; prev_a = rfsh_addr;
    for (int i = 0; i < 1200; i++) begin
      cyc(1, 8'd0, 1);
      if (prev_a == 8'd255 && rfsh_addr == 8'd0) wrapped = 1;
      if (i > 2 && !hold_req) held = 0;
      prev_a = rfsh_addr;
    end
    check(wrapped, "R6 row wrap 255->0", wrapped, 1);
    check(held, "R10 coincident expiry keeps hold", held, 1);

    // random mix
    for (int i = 0; i < 6000; i++) begin
      if (i % 97 == 0) intv = 8'($urandom_range(0, 15));
      cyc(($urandom_range(0, 9) != 0), intv, 1'($urandom_range(0, 1)));
    end
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end
endmodule